// File: doc/BRIEF.md
# Fractional Clock Divider with Periodic Tick Correction

This block divides a fast reference clock by a nominal integer count. Within each averaging window of a programmable number of output periods, it lengthens or shortens a chosen number of those periods by exactly one reference tick. A plain integer divider can only step its output frequency in coarse increments. Here the average frequency over a window moves in steps of one tick per window. With a 100 MHz reference and a nominal count of 100 (a 1 MHz output), a window of 100,000 periods with one skipped tick gives about 1,000,000.1 Hz. Longer windows give finer steps, and adjusting many periods per window covers ±200 ppm and beyond.

The adjusted periods are spread evenly over the window by an error accumulator, so they do not come in one burst. Each period drives three outputs:
- a one-tick pulse at the start of the period, usable as a clock enable;
- a square wave that is high for the first half of the period;
- a strobe marking the first period of each window.

New settings are taken only when one window ends and the next begins.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high, `tickPulse`, `squareOut` and `winStrobe` are low. In the clock cycle after the first rising edge that samples `rst` low, `tickPulse` and `winStrobe` are both high.
- R2: A period that is not adjusted lasts B reference ticks, where B is the sampled `divCount` (after clamping). `tickPulse` is high only in the first tick of each period.
- R3: When `corrInsert` = 0 (skip), an adjusted period lasts B-1 ticks.
- R4: When `corrInsert` = 1 (insert), an adjusted period lasts B+1 ticks.
- R5: Each window contains L periods, with L = `winLen`, and a `winLen` of 0 is taken as 1. Exactly N of those periods are adjusted, with N = `corrCount` (after saturation).
- R6: Number the periods of a window k = 0 to L-1. Period k is adjusted exactly when floor((k+1)·N/L) > floor(k·N/L), so the adjusted periods are spread evenly.
- R7: `winStrobe` is high in the first tick of the first period of every window, always together with `tickPulse`, and at no other time.
- R8: `divCount`, `corrCount`, `corrInsert` and `winLen` are sampled only at the clock edge that ends the last period of a window, or at a reset edge. Changes made in the middle of a window take effect from the next window.
- R9: For a period of P ticks, `squareOut` is high for the first floor(P/2) ticks and low for the rest.
- R10: A `divCount` below 2 is treated as 2.
- R11: A `corrCount` greater than L is treated as L, so every period of the window is adjusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| divCount | input | 16 | Nominal divide count B, in reference ticks |
| corrCount | input | 24 | Number of adjusted periods per window |
| corrInsert | input | 1 | 1: adjusted periods are one tick longer; 0: one tick shorter |
| winLen | input | 24 | Window length L, in output periods |
| tickPulse | output | 1 | One-tick pulse at the start of each output period |
| squareOut | output | 1 | Square wave, high for the first half of each period |
| winStrobe | output | 1 | Marks the start of the first period of each window |

## Verification
Some properties hold on every cycle, and the bound assertions check them all the time:
- the outputs stay quiet during reset;
- the window strobe only ever coincides with a period pulse;
- the pulse lasts a single tick;
- the square wave is high at the start of a period and low at its last tick;
- the period length set by the control stays fixed except at a period end.

Other behaviour only shows over whole windows, so only the bench's scenarios can confirm it:
- the exact length of each period;
- how many periods are adjusted and where they fall in the window;
- the clamping and saturation rules;
- the deferral of mid-window setting changes.

The bench checks these against a model of the even-spread rule.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Width of the nominal divide count.
  localparam int unsigned DIV_W   = 16;
  // Width of the window length and of the correction count.
  localparam int unsigned WIN_W   = 24;
  // One extra bit so that an inserted tick on the largest count cannot overflow.
  localparam int unsigned LEN_W   = DIV_W + 1;
  // Smallest nominal count the divider accepts.
  localparam int unsigned MIN_DIV = 2;

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [WIN_W-1:0] win_t;

  // What the control hands to the datapath for the period that is running.
  typedef struct packed {
    len_t periodLen;   // length of this period, in reference ticks
    logic firstOfWin;  // this period opens a window
  } ctrl2path_t;

endpackage

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             periodEnd,
  input  logic [DIV_W-1:0] divCount,
  input  win_t             corrCount,
  input  logic             corrInsert,
  input  win_t             winLen,
  output ctrl2path_t       c2p
);

  // Settings in force for the current window.
  len_t actBase;
  win_t actCorr;
  win_t actWin;
  logic actIns;

  // Spreading accumulator and index of the current period within the window.
  win_t acc;
  win_t perIdx;

  logic lastOfWin;
  logic loadNew;
  logic update;

  // Incoming settings after clamping and saturation.
  len_t rawBase;
  len_t newBase;
  win_t newWin;
  win_t newCorr;

  // Settings and accumulator value used to decide the next period.
  len_t selBase;
  win_t selWin;
  win_t selCorr;
  logic selIns;
  win_t accIn;

  win_t gap;
  logic adj;
  win_t nextAcc;
  len_t nextLen;

  assign lastOfWin = (perIdx == (actWin - win_t'(1)));
  assign loadNew   = rst || (periodEnd && lastOfWin);
  assign update    = rst || periodEnd;

  always_comb begin
    rawBase = len_t'(divCount);
    newBase = (rawBase < len_t'(MIN_DIV)) ? len_t'(MIN_DIV) : rawBase;
    newWin  = (winLen == '0) ? win_t'(1) : winLen;
    newCorr = (corrCount > newWin) ? newWin : corrCount;
  end

  always_comb begin
    selBase = loadNew ? newBase    : actBase;
    selWin  = loadNew ? newWin     : actWin;
    selCorr = loadNew ? newCorr    : actCorr;
    selIns  = loadNew ? corrInsert : actIns;
    accIn   = loadNew ? '0         : acc;
  end

  // Error-accumulator step. The accumulator stays in [0, selWin).
  // A period is adjusted when adding the correction count would reach the
  // window length.
  always_comb begin
    gap     = selWin - selCorr;
    adj     = (accIn >= gap);
    nextAcc = adj ? (accIn - gap) : (accIn + selCorr);
    if (!adj) begin
      nextLen = selBase;
    end else if (selIns) begin
      nextLen = selBase + len_t'(1);
    end else begin
      nextLen = selBase - len_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (update) begin
      actBase        <= selBase;
      actWin         <= selWin;
      actCorr        <= selCorr;
      actIns         <= selIns;
      acc            <= nextAcc;
      perIdx         <= loadNew ? '0 : (perIdx + win_t'(1));
      c2p.periodLen  <= nextLen;
      c2p.firstOfWin <= loadNew;
    end
  end

endmodule

// File: rtl/frac_div_path.sv
module frac_div_path
  import frac_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl2path_t c2p,
  output logic       periodEnd,
  output logic       tickPulse,
  output logic       squareOut,
  output logic       winStrobe
);

  logic running;
  len_t phase;
  len_t halfLen;

  assign halfLen   = c2p.periodLen >> 1;
  assign periodEnd = running && (phase == (c2p.periodLen - len_t'(1)));
  assign tickPulse = running && (phase == '0);
  assign squareOut = running && (phase < halfLen);
  assign winStrobe = tickPulse && c2p.firstOfWin;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= '0;
    end else begin
      running <= 1'b1;
      if (running) begin
        phase <= periodEnd ? '0 : (phase + len_t'(1));
      end
    end
  end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divCount,
  input  logic [WIN_W-1:0] corrCount,
  input  logic             corrInsert,
  input  logic [WIN_W-1:0] winLen,
  output logic             tickPulse,
  output logic             squareOut,
  output logic             winStrobe
);

  ctrl2path_t c2p;
  logic       periodEnd;

  frac_div_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .periodEnd  (periodEnd),
    .divCount   (divCount),
    .corrCount  (corrCount),
    .corrInsert (corrInsert),
    .winLen     (winLen),
    .c2p        (c2p)
  );

  frac_div_path u_path (
    .clk       (clk),
    .rst       (rst),
    .c2p       (c2p),
    .periodEnd (periodEnd),
    .tickPulse (tickPulse),
    .squareOut (squareOut),
    .winStrobe (winStrobe)
  );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import frac_div_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tickPulse,
  input logic       squareOut,
  input logic       winStrobe,
  input logic       periodEnd,
  input ctrl2path_t c2p
);

  // R1: the cycle after a reset edge shows no output activity.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!tickPulse && !squareOut && !winStrobe));

  // R7: a window strobe only ever comes together with a period pulse.
  p_strobe_on_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    winStrobe |-> tickPulse);

  // R2: the pulse is one tick wide whenever a period is longer than one tick.
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (tickPulse && (c2p.periodLen >= len_t'(2))) |=> !tickPulse);

  // R8: the length chosen by the control changes only where a period ends.
  p_len_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(c2p.periodLen));

  // R9: the square wave is high at the start of a period of two ticks or more.
  p_square_start_r9: assert property (@(posedge clk) disable iff (rst)
    (tickPulse && (c2p.periodLen >= len_t'(2))) |-> squareOut);

  // R9: the square wave is low in the last tick of every period.
  p_square_end_r9: assert property (@(posedge clk) disable iff (rst)
    periodEnd |-> !squareOut);

endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tickPulse (tickPulse),
  .squareOut (squareOut),
  .winStrobe (winStrobe),
  .periodEnd (periodEnd),
  .c2p       (c2p)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
  import frac_div_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] divCount;
  logic [WIN_W-1:0] corrCount;
  logic             corrInsert;
  logic [WIN_W-1:0] winLen;
  logic             tickPulse;
  logic             squareOut;
  logic             winStrobe;

  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 0;
  string scen    = "R2";

  // Model state, updated at every falling edge.
  bit  started     = 0;
  int  mBase, mN, mL;
  bit  mIns;
  int  k, cnt, hiCnt, expL, adjSeen;
  int  windowsDone = 0;

  always #5 clk = ~clk;   // 100 MHz reference

  frac_clk_div i_frac_clk_div (
    .clk        (clk),
    .rst        (rst),
    .divCount   (divCount),
    .corrCount  (corrCount),
    .corrInsert (corrInsert),
    .winLen     (winLen),
    .tickPulse  (tickPulse),
    .squareOut  (squareOut),
    .winStrobe  (winStrobe)
  );

  function automatic int effBase(int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int effWin(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int effCorr(int n, int l);
    return (n > l) ? l : n;
  endfunction

  function automatic bit isAdj(longint kk, longint n, longint l);
    return (((kk + 1) * n) / l) > ((kk * n) / l);
  endfunction

  function automatic int expLen(int b, int n, int l, bit ins, int kk);
    if (!isAdj(kk, n, l)) return b;
    return ins ? b + 1 : b - 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model of the output periods.
  always @(negedge clk) begin
    if (rst) begin
      started = 0;
      chk(!tickPulse && !squareOut && !winStrobe, "R1 outputs quiet in reset",
          {tickPulse, squareOut, winStrobe}, 0);
    end else if (tickPulse) begin
      bit newWin;
      if (started) begin
        chk(cnt == expL, {"R2 R3 R4 R6 period length ", scen}, cnt, expL);
        chk(hiCnt == expL / 2, {"R9 square high ticks ", scen}, hiCnt, expL / 2);
        if (expL != mBase) adjSeen++;
      end
      newWin = !started || (k == mL - 1);
      if (started && newWin) begin
        chk(adjSeen == mN, {"R5 adjusted periods per window ", scen}, adjSeen, mN);
        windowsDone++;
      end
      chk(winStrobe == newWin, {"R7 window strobe ", scen}, winStrobe, newWin);
      if (newWin) begin
        mBase   = effBase(int'(divCount));
        mL      = effWin(int'(winLen));
        mN      = effCorr(int'(corrCount), mL);
        mIns    = corrInsert;
        k       = 0;
        adjSeen = 0;
      end else begin
        k++;
      end
      expL    = expLen(mBase, mN, mL, mIns, k);
      cnt     = 1;
      hiCnt   = squareOut ? 1 : 0;
      started = 1;
    end else if (started) begin
      cnt++;
      if (squareOut) hiCnt++;
    end
  end

  task automatic setCfg(input int d, input int n, input int l, input bit ins);
    @(negedge clk);
    #1;
    divCount   = DIV_W'(d);
    corrCount  = WIN_W'(n);
    winLen     = WIN_W'(l);
    corrInsert = ins;
  endtask

  task automatic waitWindows(input int n);
    int target = windowsDone + n;
    while (windowsDone < target) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(tickPulse && winStrobe, "R1 first pulse after reset", {tickPulse, winStrobe}, 3);
  endtask

  initial begin
    void'($urandom(32'd20091024));
    divCount = 16'd100; corrCount = 24'd1; winLen = 24'd20; corrInsert = 1'b0;
    scen = "R3";
    doReset();
    waitWindows(2);

    scen = "R4 R6";
    setCfg(100, 3, 20, 1'b1);
    waitWindows(2);

    scen = "R2 R9 odd";
    setCfg(37, 0, 5, 1'b0);
    waitWindows(2);

    scen = "R10 low count";
    setCfg(1, 0, 4, 1'b0);
    waitWindows(2);
    scen = "R10 zero count insert";
    setCfg(0, 1, 3, 1'b1);
    waitWindows(2);
    scen = "R10 one-tick periods";
    setCfg(1, 1, 2, 1'b0);
    waitWindows(2);

    scen = "R11 saturation";
    setCfg(10, 50, 6, 1'b0);
    waitWindows(2);

    scen = "R5 zero window";
    setCfg(12, 5, 0, 1'b1);
    waitWindows(3);

    scen = "R8 mid-window change";
    setCfg(20, 2, 10, 1'b0);
    waitWindows(2);
    repeat (45) @(negedge clk);
    setCfg(30, 7, 8, 1'b1);
    waitWindows(2);

    for (int i = 0; i < 12; i++) begin
      int d, n, l;
      bit ins;
      d   = ($urandom_range(9) == 0) ? int'($urandom_range(1)) : int'($urandom_range(60, 2));
      l   = int'($urandom_range(40));
      n   = int'($urandom_range(45));
      ins = 1'($urandom_range(1));
      scen = "R6 R8 random";
      repeat ($urandom_range(300)) @(negedge clk);
      setCfg(d, n, l, ins);
      waitWindows(2);
    end

    scen = "R1 second reset";
    setCfg(100, 1, 20, 1'b0);
    doReset();
    waitWindows(1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", windowsDone, -1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule